// File: doc/BRIEF.md
# Track Format Byte Counter

This block runs the format (write-track) path of a single-density floppy controller. After a format command, the host writes a complete raw track image one byte at a time through a data-write strobe. The block counts every byte it accepts. It keeps only the fill bytes (value 0xE5) as sector data and stores them in a sector buffer. When a sector's worth of fill bytes has been gathered, it hands the buffer to a downstream commit agent and waits for that agent to report back. It stops when a full raw track's worth of bytes has arrived. In this way a fixed byte count stands in for the index pulse.

The commit agent reads the buffer through a registered read port while `commit_req` is high. The commit request also carries the sector number to write. The agent finishes with a one-cycle `commit_done` pulse, together with a pass/fail flag. The status byte, the sector number and the interrupt request give the host everything it polls during a format.

The sizes are parameters: sector length (a power of two), sectors per track, raw bytes per sector and fixed track overhead. The defaults give 128-byte sectors, 26 sectors and a raw track of 26×186+320 = 5156 bytes.

Top module: `fmt_track_writer`

## Requirements
- R1: After reset, `status` is 0x00, `intrq` is 0, `byte_count` is 0, `sector_num` is 0 and `commit_req` is 0.
- R2: A format start without write protect takes effect in the following cycle. It zeroes `byte_count` and the fill count, sets `sector_num` to 1 and sets `status` to 0x03 (bit 0 busy, bit 1 data request).
- R3: A format start while `wr_protect` is high does not start a format. In the following cycle it sets `status` to 0x40 (bit 6 write protect) and raises `intrq`. Later data writes leave `byte_count` and `status` unchanged.
- R4: Each data write accepted while the data request is set raises `byte_count` by one, whatever the byte value. Until the track ends or a commit is pending, `status` stays 0x03, with 0x20 (bit 5 write fault) added after a failed commit.
- R5: Only bytes equal to 0xE5 are stored in the sector buffer. The sector is offered for commit exactly when the SEC_LEN-th fill byte since the start of the sector is accepted.
- R6: While a commit is pending, `commit_req` is 1, `sector_num` is the sector being committed and the data request is clear (`status` 0x01). Data writes in that time are ignored and leave `byte_count` unchanged.
- R7: A `commit_done` pulse during a pending commit does three things: it advances `sector_num` by one, sets the write fault bit if `commit_ok` is low (and clears it otherwise), and drops `commit_req`. A `commit_done` pulse with no commit pending has no effect.
- R8: When `byte_count` reaches the raw track length, with any commit pending for the last byte resolved first, `status` becomes 0x00, `intrq` rises and `commit_req` is 0.
- R9: Data writes after the track has ended are ignored: `byte_count`, `sector_num`, `status` and `intrq` do not change.
- R10: A forced abort clears busy and the data request, drops `commit_req` and zeroes `byte_count` and the fill count in the following cycle. Later data writes are ignored.
- R11: A format start clears `intrq`.
- R12: `buf_rd_data` returns the buffer entry at `buf_rd_addr` one cycle after the address is presented. Every entry of a committed sector holds 0xE5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_start | input | 1 | One-cycle format command strobe |
| wr_protect | input | 1 | Write-protect level, sampled on `fmt_start` |
| force_abort | input | 1 | One-cycle abort strobe |
| wr_en | input | 1 | Data-register write strobe |
| wr_data | input | 8 | Raw track byte |
| commit_done | input | 1 | One-cycle pulse from the commit agent that ends a commit |
| commit_ok | input | 1 | Commit result, valid with `commit_done` |
| buf_rd_addr | input | log2(SEC_LEN) | Sector buffer read address |
| buf_rd_data | output | 8 | Sector buffer read data, one cycle latency |
| commit_req | output | 1 | A full sector is waiting to be committed |
| sector_num | output | 8 | Current sector number |
| byte_count | output | clog2(track length+1) | Raw bytes accepted in this track |
| status | output | 8 | Status byte: bit 0 busy, bit 1 data request, bit 5 write fault, bit 6 write protect |
| intrq | output | 1 | Interrupt request |

## Verification
The assertions assume that `commit_done` and `force_abort` are single-cycle pulses. They also assume that `fmt_start` and `force_abort` are never high in the same cycle, and that reset is held for several cycles before any strobe. The bench drives every strobe for exactly one cycle on the falling edge and never overlaps start with abort. It pulses `commit_done` once per pending sector. The only `commit_done` it sends with no commit pending is a deliberate one, used to check that such a pulse is ignored. The sweep uses a small configuration (4-byte sectors, 30-byte track). This covers patterns where fill and non-fill bytes interleave at different densities, including one where the last track byte also completes a sector.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [1:0] {
    FMT_IDLE   = 2'd0,
    FMT_FILL   = 2'd1,
    FMT_COMMIT = 2'd2
  } fmt_state_t;

  localparam int ST_BUSY   = 0;
  localparam int ST_DRQ    = 1;
  localparam int ST_WFAULT = 5;
  localparam int ST_WPROT  = 6;

endpackage

// File: rtl/fmt_counter.sv
module fmt_counter #(
  parameter int WIDTH = 8,
  parameter int LIMIT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] cnt,
  output logic             last
);
  localparam logic [WIDTH-1:0] LIM_V  = WIDTH'(LIMIT);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LIMIT - 1);

  // Saturates at LIMIT so stray increments cannot wrap the count
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != LIM_V)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == LAST_V);
endmodule

// File: rtl/fmt_sector_buf.sv
module fmt_sector_buf #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port shape with registered read for block RAM inference
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa] <= wd;
    end
    rd <= mem[ra];
  end
endmodule

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import fmt_pkg::*;
#(
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wprot,
  input  logic             abort,
  input  logic             wr_en,
  input  logic             is_fill,
  input  logic             fill_last,
  input  logic             trk_last,
  input  logic             trk_full,
  input  logic             commit_done,
  input  logic             commit_ok,
  output logic             accept,
  output logic             trk_clr,
  output logic             fill_clr,
  output logic             drq,
  output logic             busy,
  output logic             wfault,
  output logic             wp_flag,
  output logic             intrq,
  output logic             commit_req,
  output logic [SEC_W-1:0] sector
);
  fmt_state_t state;

  always_comb begin
    accept   = wr_en && (state == FMT_FILL) && !start && !abort;
    trk_clr  = abort || (start && !wprot);
    fill_clr = trk_clr || (accept && is_fill && fill_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FMT_IDLE;
      busy   <= 1'b0;
      wfault <= 1'b0;
      wp_flag <= 1'b0;
      intrq  <= 1'b0;
      sector <= '0;
    end else if (abort) begin
      state <= FMT_IDLE;
      busy  <= 1'b0;
    end else if (start) begin
      intrq  <= wprot;
      wp_flag <= wprot;
      wfault <= 1'b0;
      if (wprot) begin
        state <= FMT_IDLE;
        busy  <= 1'b0;
      end else begin
        state  <= FMT_FILL;
        busy   <= 1'b1;
        sector <= SEC_W'(1);
      end
    end else begin
      case (state)
        FMT_FILL: begin
          if (accept) begin
            if (is_fill && fill_last) begin
              state <= FMT_COMMIT;
            end else if (trk_last) begin
              state  <= FMT_IDLE;
              busy   <= 1'b0;
              wfault <= 1'b0;
              wp_flag <= 1'b0;
              intrq  <= 1'b1;
            end
          end
        end
        FMT_COMMIT: begin
          if (commit_done) begin
            sector <= sector + 1'b1;
            if (trk_full) begin
              state  <= FMT_IDLE;
              busy   <= 1'b0;
              wfault <= 1'b0;
              wp_flag <= 1'b0;
              intrq  <= 1'b1;
            end else begin
              state  <= FMT_FILL;
              wfault <= !commit_ok;
            end
          end
        end
        default: state <= FMT_IDLE;
      endcase
    end
  end

  assign drq        = (state == FMT_FILL);
  assign commit_req = (state == FMT_COMMIT);
endmodule

// File: rtl/fmt_track_writer.sv
module fmt_track_writer
  import fmt_pkg::*;
#(
  parameter int          SEC_LEN     = 128,
  parameter int          SECTORS     = 26,
  parameter int          SEC_RAW_LEN = 186,
  parameter int          TRACK_EXTRA = 320,
  parameter logic [7:0]  FILL_BYTE   = 8'hE5,
  localparam int         TRACK_LEN   = SECTORS * SEC_RAW_LEN + TRACK_EXTRA,
  localparam int         CW          = $clog2(TRACK_LEN + 1),
  localparam int         AW          = $clog2(SEC_LEN),
  localparam int         FW          = $clog2(SEC_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fmt_start,
  input  logic          wr_protect,
  input  logic          force_abort,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          commit_done,
  input  logic          commit_ok,
  input  logic [AW-1:0] buf_rd_addr,
  output logic [7:0]    buf_rd_data,
  output logic          commit_req,
  output logic [7:0]    sector_num,
  output logic [CW-1:0] byte_count,
  output logic [7:0]    status,
  output logic          intrq
);
  localparam logic [CW-1:0] TRACK_LEN_V = CW'(TRACK_LEN);

  logic          accept, trk_clr, fill_clr;
  logic          trk_last, fill_last, trk_full, is_fill;
  logic          drq, busy, wfault, wp_flag;
  logic [FW-1:0] fill_cnt;

  assign is_fill  = (wr_data == FILL_BYTE);
  assign trk_full = (byte_count == TRACK_LEN_V);

  fmt_counter #(.WIDTH(CW), .LIMIT(TRACK_LEN)) trk_ctr_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (trk_clr),
    .inc  (accept),
    .cnt  (byte_count),
    .last (trk_last)
  );

  fmt_counter #(.WIDTH(FW), .LIMIT(SEC_LEN)) fill_ctr_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (fill_clr),
    .inc  (accept && is_fill),
    .cnt  (fill_cnt),
    .last (fill_last)
  );

  fmt_sector_buf #(.AW(AW), .DW(8)) buf_i (
    .clk (clk),
    .we  (accept && is_fill),
    .wa  (fill_cnt[AW-1:0]),
    .wd  (wr_data),
    .ra  (buf_rd_addr),
    .rd  (buf_rd_data)
  );

  fmt_ctrl #(.SEC_W(8)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start       (fmt_start),
    .wprot       (wr_protect),
    .abort       (force_abort),
    .wr_en       (wr_en),
    .is_fill     (is_fill),
    .fill_last   (fill_last),
    .trk_last    (trk_last),
    .trk_full    (trk_full),
    .commit_done (commit_done),
    .commit_ok   (commit_ok),
    .accept      (accept),
    .trk_clr     (trk_clr),
    .fill_clr    (fill_clr),
    .drq         (drq),
    .busy        (busy),
    .wfault      (wfault),
    .wp_flag     (wp_flag),
    .intrq       (intrq),
    .commit_req  (commit_req),
    .sector      (sector_num)
  );

  always_comb begin
    status            = '0;
    status[ST_BUSY]   = busy;
    status[ST_DRQ]    = drq;
    status[ST_WFAULT] = wfault;
    status[ST_WPROT]  = wp_flag;
  end
endmodule

// File: rtl/fmt_track_writer_chk.sv
module fmt_track_writer_chk #(
  parameter int SECTORS     = 26,
  parameter int SEC_RAW_LEN = 186,
  parameter int TRACK_EXTRA = 320,
  localparam int TRACK_LEN  = SECTORS * SEC_RAW_LEN + TRACK_EXTRA,
  localparam int CW         = $clog2(TRACK_LEN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          abort,
  input logic          commit_done,
  input logic          commit_req,
  input logic [1:0]    st_low,
  input logic          intrq,
  input logic [CW-1:0] byte_count
);
  // R6
  commit_holds_drq_chk: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> !st_low[1]);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    intrq |-> (st_low == 2'b00 && !commit_req));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(byte_count) <= TRACK_LEN);

  // R4
  count_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !abort) |=> (byte_count >= $past(byte_count)));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (st_low == 2'b00 && byte_count == '0 && !commit_req));

  // R7
  commit_release_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_req && commit_done && !abort && !start) |=> !commit_req);
endmodule

bind fmt_track_writer fmt_track_writer_chk #(
  .SECTORS     (SECTORS),
  .SEC_RAW_LEN (SEC_RAW_LEN),
  .TRACK_EXTRA (TRACK_EXTRA)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start       (fmt_start),
  .abort       (force_abort),
  .commit_done (commit_done),
  .commit_req  (commit_req),
  .st_low      (status[1:0]),
  .intrq       (intrq),
  .byte_count  (byte_count)
);

// File: tb/fmt_track_writer_tb.sv
module fmt_track_writer_tb_top;
  localparam int SEC_LEN   = 4;
  localparam int SECTORS   = 3;
  localparam int SEC_RAW   = 8;
  localparam int EXTRA     = 6;
  localparam int TRACK_LEN = SECTORS * SEC_RAW + EXTRA;
  localparam int CW        = $clog2(TRACK_LEN + 1);
  localparam int AW        = $clog2(SEC_LEN);
  localparam logic [7:0] FILL = 8'hE5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fmt_start = 1'b0, wr_protect = 1'b0, force_abort = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          commit_done = 1'b0, commit_ok = 1'b0;
  logic [AW-1:0] buf_rd_addr = '0;
  logic [7:0]    buf_rd_data;
  logic          commit_req;
  logic [7:0]    sector_num;
  logic [CW-1:0] byte_count;
  logic [7:0]    status;
  logic          intrq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fmt_track_writer #(
    .SEC_LEN(SEC_LEN), .SECTORS(SECTORS), .SEC_RAW_LEN(SEC_RAW),
    .TRACK_EXTRA(EXTRA), .FILL_BYTE(FILL)
  ) dut_i (
    .clk(clk), .rst(rst), .fmt_start(fmt_start), .wr_protect(wr_protect),
    .force_abort(force_abort), .wr_en(wr_en), .wr_data(wr_data),
    .commit_done(commit_done), .commit_ok(commit_ok),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .commit_req(commit_req), .sector_num(sector_num),
    .byte_count(byte_count), .status(status), .intrq(intrq)
  );

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_start(bit wp);
    wr_protect = wp;
    fmt_start  = 1'b1;
    @(negedge clk);
    fmt_start  = 1'b0;
    wr_protect = 1'b0;
  endtask

  task automatic do_abort();
    force_abort = 1'b1;
    @(negedge clk);
    force_abort = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v);
    wr_data = v;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic pulse_done(bit ok);
    commit_ok   = ok;
    commit_done = 1'b1;
    @(negedge clk);
    commit_done = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 status", int'(status), 0);
    check_eq("R1 intrq", int'(intrq), 0);
    check_eq("R1 byte_count", int'(byte_count), 0);
    check_eq("R1 sector_num", int'(sector_num), 0);
    check_eq("R1 commit_req", int'(commit_req), 0);

    // R3 protected start
    do_start(1'b1);
    check_eq("R3 status", int'(status), 8'h40);
    check_eq("R3 intrq", int'(intrq), 1);
    check_eq("R3 sector_num", int'(sector_num), 0);
    send_byte(FILL);
    check_eq("R3 byte_count after write", int'(byte_count), 0);
    check_eq("R3 status after write", int'(status), 8'h40);

    // Sweep over fill densities; run 6 ends a sector on the last track byte
    for (int run = 0; run < 7; run++) begin
      int  exp_cnt, fc, exp_sec;
      bit  wf, fin;
      do_start(1'b0);
      check_eq("R2 status", int'(status), 8'h03);
      check_eq("R2 sector_num", int'(sector_num), 1);
      check_eq("R2 byte_count", int'(byte_count), 0);
      check_eq("R11 intrq cleared", int'(intrq), 0);
      exp_cnt = 0; fc = 0; exp_sec = 1; wf = 1'b0; fin = 1'b0;
      for (int i = 0; i < TRACK_LEN; i++) begin
        logic [7:0] v;
        if (run == 6) v = (i < 2) ? 8'(i) : FILL;
        else          v = (((i + run) % (run + 2)) == 0) ? 8'(i) : FILL;
        send_byte(v);
        exp_cnt++;
        if (v == FILL) fc++;
        check_eq("R4 byte_count", int'(byte_count), exp_cnt);
        if (fc == SEC_LEN) begin
          bit ok;
          fc = 0;
          check_eq("R5 commit_req at sector end", int'(commit_req), 1);
          check_eq("R6 status during commit", int'(status), wf ? 8'h21 : 8'h01);
          check_eq("R6 commit sector", int'(sector_num), exp_sec);
          send_byte(FILL);
          check_eq("R6 write ignored during commit", int'(byte_count), exp_cnt);
          for (int k = 0; k < SEC_LEN; k++) begin
            buf_rd_addr = AW'(k);
            @(negedge clk);
            check_eq("R12 buffer content", int'(buf_rd_data), int'(FILL));
          end
          ok = ((exp_sec + run) % 3) != 0;
          pulse_done(ok);
          exp_sec++;
          check_eq("R7 sector advance", int'(sector_num), exp_sec);
          check_eq("R7 commit_req released", int'(commit_req), 0);
          if (exp_cnt == TRACK_LEN) begin
            fin = 1'b1;
            check_eq("R8 status at end after commit", int'(status), 0);
            check_eq("R8 intrq at end after commit", int'(intrq), 1);
          end else begin
            wf = !ok;
            check_eq("R7 write fault", int'(status), wf ? 8'h23 : 8'h03);
          end
        end else if (exp_cnt == TRACK_LEN) begin
          fin = 1'b1;
          check_eq("R8 status at end", int'(status), 0);
          check_eq("R8 intrq at end", int'(intrq), 1);
          check_eq("R8 commit_req at end", int'(commit_req), 0);
        end else begin
          check_eq("R4 status mid track", int'(status), wf ? 8'h23 : 8'h03);
          check_eq("R5 no early commit", int'(commit_req), 0);
        end
      end
      check_eq("R8 track finished", int'(fin), 1);
      for (int j = 0; j < 3; j++) send_byte(FILL);
      check_eq("R9 byte_count frozen", int'(byte_count), TRACK_LEN);
      check_eq("R9 sector frozen", int'(sector_num), exp_sec);
      check_eq("R9 status frozen", int'(status), 0);
      check_eq("R9 intrq held", int'(intrq), 1);
    end

    // R10 abort mid track
    do_start(1'b0);
    send_byte(FILL); send_byte(8'h00); send_byte(FILL); send_byte(FILL); send_byte(8'h01);
    check_eq("R10 count before abort", int'(byte_count), 5);
    do_abort();
    check_eq("R10 status after abort", int'(status), 0);
    check_eq("R10 byte_count after abort", int'(byte_count), 0);
    check_eq("R10 intrq after abort", int'(intrq), 0);
    send_byte(FILL);
    check_eq("R10 write after abort ignored", int'(byte_count), 0);

    // R10 abort during commit, then stray commit_done
    do_start(1'b0);
    for (int j = 0; j < SEC_LEN; j++) send_byte(FILL);
    check_eq("R6 commit pending", int'(commit_req), 1);
    do_abort();
    check_eq("R10 commit_req after abort", int'(commit_req), 0);
    check_eq("R10 count after abort", int'(byte_count), 0);
    pulse_done(1'b0);
    check_eq("R7 stray done sector", int'(sector_num), 1);
    check_eq("R7 stray done status", int'(status), 0);

    // R5 fill count restarts on a new start
    do_start(1'b0);
    for (int j = 0; j < SEC_LEN - 1; j++) send_byte(FILL);
    check_eq("R5 no commit before sector full", int'(commit_req), 0);
    send_byte(FILL);
    check_eq("R5 commit after sector full", int'(commit_req), 1);
    pulse_done(1'b1);
    check_eq("R7 ok commit status", int'(status), 8'h03);
    check_eq("R7 ok commit sector", int'(sector_num), 2);

    summary();
    $finish;
  end
endmodule